// File: doc/BRIEF.md
# Two-Level Short-Descriptor Page Table Walker

This block turns a 32-bit input address into a 32-bit output address by reading a two-level page table from memory. A request carries the input address and a first-level table base. The walker reads one first-level descriptor. If that descriptor points at a second-level table, it reads one more. It then decodes the leaf entry into an output address, permissions, a memory type and a mapping size. Only one walk is in flight at a time.

Mappings come in four sizes: 4 KB small pages, 64 KB large pages, 1 MB sections and 16 MB supersections. Large pages and supersections are stored as one descriptor copied into 16 neighbouring slots. In a large page the execute-never bit and the memory-type field sit in different positions than in a small page. The decoder follows those moves.

Memory is reached through a plain read port. The walker raises a one-cycle read strobe with an address and then waits, for any number of cycles, until the memory returns data with a valid strobe.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` then stays low until the cycle after the response pulse, so only one walk is outstanding at a time.
- R2: The first read goes to {base[31:14], va[31:20], 2'b00}. Base bits [13:0] have no effect.
- R3: A first-level descriptor with bit 0 set is a table pointer. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R4: A descriptor whose bits [1:0] are 00 ends the walk at that level. The response then has fault=1, access-fault kind=0, output address 0, writable, executable, device and cacheable all 0, size code 0, and level set to the level where the walk stopped. No further read is issued.
- R5: A first-level descriptor with bits [1:0]=10 and bit 18 clear is a 1 MB section. The output address is {desc[31:20], va[19:0]}, the level is 1 and the size code is 2.
- R6: A section with bit 18 set is a 16 MB supersection. The output address is {desc[31:24], va[23:0]} and the size code is 3.
- R7: A second-level descriptor with bit 1 set is a 4 KB page. The output address is {desc[31:12], va[11:0]}, the level is 2 and the size code is 0.
- R8: A second-level descriptor with bits [1:0]=01 is a 64 KB large page. The output address is {desc[31:16], va[15:0]} and the size code is 1. The result is the same whichever of the 16 replicated slots is read.
- R9: The writable flag is the inverse of the read-only bit. That bit is desc[15] in a section and desc[9] in a second-level page (bit 5 of the attribute group, which sits at [17:10] or [11:4]).
- R10: The executable flag is the inverse of the execute-never bit. That bit is desc[4] in a section, desc[0] in a small page and desc[15] in a large page.
- R11: The 3-bit memory-type field is desc[14:12] in a section or a large page, and desc[8:6] in a small page. Device is reported when the field is 0. Cacheable is reported when the field is nonzero and desc[3] is set.
- R12: A leaf whose access flag is clear gives an access fault. The access flag is desc[10] in a section and desc[4] in a page. The response then has fault=1, access-fault kind=1, the leaf level, and every other field 0.
- R13: The walker accepts a descriptor only in a cycle where the read-data valid strobe is high. The result does not depend on memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Input address to translate |
| req_base | input | 32 | First-level table base (bits [31:14] used) |
| mem_req | output | 1 | One-cycle descriptor read strobe |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Output address |
| rsp_wr | output | 1 | Mapping is writable |
| rsp_ex | output | 1 | Mapping is executable |
| rsp_dev | output | 1 | Device memory type |
| rsp_cache | output | 1 | Cacheable memory type |
| rsp_fault | output | 1 | Walk faulted |
| rsp_acc_flt | output | 1 | Fault kind: 1 = access flag clear, 0 = invalid descriptor |
| rsp_lvl | output | 2 | Level where the walk ended (1 or 2) |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |

## Verification
The embedded assertions check the following rules on every cycle:
- A taken request drops the ready signal, so walks never overlap.
- A read strobe never lasts two cycles or runs straight into a response.
- A faulted response has a zero address and no permissions.
- The low offset bits of a successful translation, and all 24 low bits of a supersection, pass through from the captured input address.

Only the bench's scenarios can show the rest:
- The level-dependent positions of the permission bits, the execute-never bit and the memory-type field.
- The table-pointer address.
- Slot-independence of a replicated large page.
- The count of reads per walk.
- Tolerance of different read latencies.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int VA_W      = 32;
    localparam int DESC_W    = 32;
    localparam int L1_IDX_W  = 12;
    localparam int L2_IDX_W  = 8;
    localparam int PG_OFS_W  = 12;
    localparam int ENT_SH    = 2;
    localparam int L1_IDX_LSB = VA_W - L1_IDX_W;
    localparam int L1_ALIGN   = L1_IDX_W + ENT_SH;
    localparam int L2_ALIGN   = L2_IDX_W + ENT_SH;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } map_sz_e;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        logic            wr;
        logic            ex;
        logic            dev;
        logic            cch;
        logic            fault;
        logic            acc_flt;
        logic [1:0]      lvl;
        map_sz_e         size;
    } walk_rsp_t;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
    import pt_walker_pkg::*;
(
    input  logic [VA_W-1:0]   base_i,
    input  logic [VA_W-1:0]   new_va_i,
    input  logic [VA_W-1:0]   walk_va_i,
    input  logic [DESC_W-1:0] tbl_desc_i,
    output logic [VA_W-1:0]   l1_addr_o,
    output logic [VA_W-1:0]   l2_addr_o
);
    logic unused_bits;

    // first-level slot: aligned base plus top index
    assign l1_addr_o = {base_i[VA_W-1:L1_ALIGN], new_va_i[VA_W-1:L1_IDX_LSB],
                        {ENT_SH{1'b0}}};
    // second-level slot: table pointer plus middle index
    assign l2_addr_o = {tbl_desc_i[DESC_W-1:L2_ALIGN],
                        walk_va_i[PG_OFS_W+L2_IDX_W-1:PG_OFS_W], {ENT_SH{1'b0}}};

    assign unused_bits = ^{base_i[L1_ALIGN-1:0], new_va_i[L1_IDX_LSB-1:0],
                           walk_va_i[VA_W-1:PG_OFS_W+L2_IDX_W],
                           walk_va_i[PG_OFS_W-1:0], tbl_desc_i[L2_ALIGN-1:0]};
endmodule

// File: rtl/pt_leaf_decode.sv
module pt_leaf_decode
    import pt_walker_pkg::*;
#(
    parameter bit SECOND = 1'b0
) (
    input  logic [DESC_W-1:0] desc_i,
    input  logic [VA_W-1:0]   va_i,
    output walk_rsp_t         rsp_o
);
    logic            big;
    logic [7:0]      grp;
    logic [2:0]      mtype;
    logic            xn;
    logic [VA_W-1:0] pa;
    map_sz_e         sz;
    logic            unused_bits;

    generate
        if (SECOND) begin : g_lvl2
            always_comb begin
                big   = ~desc_i[1];
                grp   = desc_i[11:4];
                mtype = big ? desc_i[14:12] : grp[4:2];
                xn    = big ? desc_i[15] : desc_i[0];
                pa    = big ? {desc_i[31:16], va_i[15:0]}
                            : {desc_i[31:12], va_i[11:0]};
                sz    = big ? SZ_64K : SZ_4K;
            end
            assign unused_bits = ^{va_i[31:16], desc_i[2], grp[1], grp[7:6]};
        end else begin : g_lvl1
            always_comb begin
                big   = desc_i[18];
                grp   = desc_i[17:10];
                mtype = grp[4:2];
                xn    = desc_i[4];
                pa    = big ? {desc_i[31:24], va_i[23:0]}
                            : {desc_i[31:20], va_i[19:0]};
                sz    = big ? SZ_16M : SZ_1M;
            end
            assign unused_bits = ^{va_i[31:24], desc_i[19], desc_i[9:5],
                                   desc_i[2], grp[1], grp[7:6]};
        end
    endgenerate

    always_comb begin
        rsp_o     = '0;
        rsp_o.lvl = SECOND ? 2'd2 : 2'd1;
        if (desc_i[1:0] == 2'b00) begin
            rsp_o.fault = 1'b1;
        end else if (!grp[0]) begin
            rsp_o.fault   = 1'b1;
            rsp_o.acc_flt = 1'b1;
        end else begin
            rsp_o.pa   = pa;
            rsp_o.wr   = ~grp[5];
            rsp_o.ex   = ~xn;
            rsp_o.dev  = (mtype == 3'd0);
            rsp_o.cch  = (mtype != 3'd0) && desc_i[3];
            rsp_o.size = sz;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [VA_W-1:0]   req_base,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_wr,
    output logic              rsp_ex,
    output logic              rsp_dev,
    output logic              rsp_cache,
    output logic              rsp_fault,
    output logic              rsp_acc_flt,
    output logic [1:0]        rsp_lvl,
    output logic [1:0]        rsp_size
);
    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic [VA_W-1:0] addr;
        walk_rsp_t       rsp;
    } walk_state_t;

    walk_state_t     cur_q, nxt_d;
    logic [VA_W-1:0] l1_addr, l2_addr;
    walk_rsp_t       l1_rsp, l2_rsp;

    pt_walk_addr u_addr (
        .base_i     (req_base),
        .new_va_i   (req_va),
        .walk_va_i  (cur_q.va),
        .tbl_desc_i (mem_rdata),
        .l1_addr_o  (l1_addr),
        .l2_addr_o  (l2_addr)
    );

    pt_leaf_decode #(.SECOND(1'b0)) u_dec_l1 (
        .desc_i (mem_rdata),
        .va_i   (cur_q.va),
        .rsp_o  (l1_rsp)
    );

    pt_leaf_decode #(.SECOND(1'b1)) u_dec_l2 (
        .desc_i (mem_rdata),
        .va_i   (cur_q.va),
        .rsp_o  (l2_rsp)
    );

    always_comb begin
        nxt_d   = cur_q;
        mem_req = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.va   = req_va;
                    nxt_d.addr = l1_addr;
                    nxt_d.st   = ST_L1_REQ;
                end
            end
            ST_L1_REQ: begin
                mem_req  = 1'b1;
                nxt_d.st = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_rdata[0]) begin
                        nxt_d.addr = l2_addr;
                        nxt_d.st   = ST_L2_REQ;
                    end else begin
                        nxt_d.rsp = l1_rsp;
                        nxt_d.st  = ST_RESP;
                    end
                end
            end
            ST_L2_REQ: begin
                mem_req  = 1'b1;
                nxt_d.st = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rvalid) begin
                    nxt_d.rsp = l2_rsp;
                    nxt_d.st  = ST_RESP;
                end
            end
            ST_RESP: nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign req_ready   = (cur_q.st == ST_IDLE);
    assign mem_addr    = cur_q.addr;
    assign rsp_valid   = (cur_q.st == ST_RESP);
    assign rsp_pa      = cur_q.rsp.pa;
    assign rsp_wr      = cur_q.rsp.wr;
    assign rsp_ex      = cur_q.rsp.ex;
    assign rsp_dev     = cur_q.rsp.dev;
    assign rsp_cache   = cur_q.rsp.cch;
    assign rsp_fault   = cur_q.rsp.fault;
    assign rsp_acc_flt = cur_q.rsp.acc_flt;
    assign rsp_lvl     = cur_q.rsp.lvl;
    assign rsp_size    = cur_q.rsp.size;

    // R1
    one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R13
    rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (!mem_req && !rsp_valid));

    // R4 R12
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_wr && !rsp_ex));

    // R6
    super_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_size == SZ_16M)
            |-> (rsp_pa[23:0] == cur_q.va[23:0]));

    // R7
    page_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault)
            |-> (rsp_pa[PG_OFS_W-1:0] == cur_q.va[PG_OFS_W-1:0]));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TB = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] req_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_wr, rsp_ex, rsp_dev, rsp_cache, rsp_fault, rsp_acc_flt;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_lvl, rsp_size;

    int vectors = 0;
    int misses  = 0;
    int lat     = 1;
    int rd_cnt  = 0;

    logic [31:0] mem [logic [31:0]];

    typedef struct {
        logic [45:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_base(req_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
        .rsp_dev(rsp_dev), .rsp_cache(rsp_cache), .rsp_fault(rsp_fault),
        .rsp_acc_flt(rsp_acc_flt), .rsp_lvl(rsp_lvl), .rsp_size(rsp_size)
    );

    function automatic logic [45:0] mk(input logic [31:0] pa, input logic wr, ex, dev,
                                      cch, flt, acc, input logic [1:0] lvl, sz,
                                      input logic [3:0] nrd);
        return {pa, wr, ex, dev, cch, flt, acc, lvl, sz, nrd};
    endfunction

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder: answers each read strobe after lat cycles
    initial begin
        @(negedge clk);
        forever begin
            if (mem_req) begin
                logic [31:0] a;
                a = mem_addr;
                rd_cnt++;
                repeat (lat) @(negedge clk);
                mem_rdata  = rd(a);
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEAD_BEEF;
            end else begin
                @(negedge clk);
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                logic [45:0] act;
                exp_t e;
                act = {rsp_pa, rsp_wr, rsp_ex, rsp_dev, rsp_cache, rsp_fault,
                       rsp_acc_flt, rsp_lvl, rsp_size, 4'(rd_cnt)};
                rd_cnt = 0;
                vectors++;
                if (q.size() == 0) begin
                    misses++;
                    $display("FAIL R1 unexpected response: actual %h expected none", act);
                end else begin
                    e = q.pop_front();
                    if (act !== e.v) begin
                        misses++;
                        $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
                    end
                end
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [45:0] ev, input string tag);
        exp_t e;
        e.v = ev;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_va    = va;
        req_base  = base;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        vectors++;
        if (req_ready !== 1'b0) begin
            misses++;
            $display("FAIL R1 ready during walk: actual %b expected 0", req_ready);
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic run_all();
        // R5 R9 R10 R11: section, writable, execute-never, cacheable
        walk(32'h1230_0ABC, TB, mk(32'h4560_0ABC,1,0,0,1,0,0,2'd1,2'd2,4'd1),
             "R5 R9 R10 R11 section");
        // R2: low base bits ignored
        walk(32'h1230_0ABC, TB | 32'h0000_3FFF,
             mk(32'h4560_0ABC,1,0,0,1,0,0,2'd1,2'd2,4'd1), "R2 base low bits");
        // R6 R9 R11: supersection, read-only, device
        walk(32'h2A54_3210, TB, mk(32'h9B54_3210,0,1,1,0,0,0,2'd1,2'd3,4'd1),
             "R6 R9 R11 supersection");
        // R3 R7 R11: small page through table pointer
        walk(32'h0037_5ABC, TB, mk(32'h7788_9ABC,1,1,0,0,0,0,2'd2,2'd0,4'd2),
             "R3 R7 R11 small page");
        // R10 R9: small page execute-never at bit 0, read-only
        walk(32'h0037_6000, TB, mk(32'h1111_2000,0,0,1,0,0,0,2'd2,2'd0,4'd2),
             "R10 R9 small page xn");
        // R8 R11: large page, two replicated slots
        walk(32'h0045_3123, TB, mk(32'hABCD_3123,0,1,0,1,0,0,2'd2,2'd1,4'd2),
             "R8 R11 large page slot a");
        walk(32'h0045_E456, TB, mk(32'hABCD_E456,0,1,0,1,0,0,2'd2,2'd1,4'd2),
             "R8 large page slot b");
        // R10: large page execute-never at bit 15
        walk(32'h0045_F000, TB, mk(32'hABCD_F000,0,0,0,1,0,0,2'd2,2'd1,4'd2),
             "R10 large page xn");
        // R4: invalid descriptors
        walk(32'h7FF0_0000, TB, mk(32'h0,0,0,0,0,1,0,2'd1,2'd0,4'd1), "R4 empty l1");
        walk(32'h8000_0004, TB, mk(32'h0,0,0,0,0,1,0,2'd1,2'd0,4'd1), "R4 type 00 l1");
        walk(32'h0037_7000, TB, mk(32'h0,0,0,0,0,1,0,2'd2,2'd0,4'd2), "R4 empty l2");
        // R12: access flag clear
        walk(32'h5000_0000, TB, mk(32'h0,0,0,0,0,1,1,2'd1,2'd0,4'd1), "R12 l1 access");
        walk(32'h0037_8000, TB, mk(32'h0,0,0,0,0,1,1,2'd2,2'd0,4'd2), "R12 l2 access");
    endtask

    initial begin
        mem[32'h0010_048C] = 32'h4560_1C1E;
        mem[32'h0010_0A94] = 32'h9B04_8406;
        mem[32'h0010_000C] = 32'h0020_0401;
        mem[32'h0020_05D4] = 32'h7788_9076;
        mem[32'h0020_05D8] = 32'h1111_2233;
        mem[32'h0020_05E0] = 32'h2222_2002;
        mem[32'h0010_0010] = 32'h0030_0001;
        mem[32'h0030_014C] = 32'hABCD_121D;
        mem[32'h0030_0178] = 32'hABCD_121D;
        mem[32'h0030_017C] = 32'hABCD_921D;
        mem[32'h0010_2000] = 32'hFFFF_FFFC;
        mem[32'h0010_1400] = 32'h1230_0002;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0) begin
            misses++;
            $display("FAIL R1 reset state: actual %b%b%b expected 100",
                     req_ready, rsp_valid, mem_req);
        end

        lat = 1;
        run_all();
        // R13: same walks under longer read latency
        lat = 4;
        run_all();
        lat = 2;
        walk(32'h0037_5ABC, TB, mk(32'h7788_9ABC,1,1,0,0,0,0,2'd2,2'd0,4'd2),
             "R13 latency 2");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        misses++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule